// File: doc/BRIEF.md
# ADC Conversion Result Register with Selectable Justification

This block sits between an analog-to-digital converter's sequencer and a byte-wide host bus. Each finished 10-bit conversion arrives as a one-cycle offer on a valid/ready input. The block formats the result into a high and a low data byte, using one of four layouts chosen by a 2-bit format field. It also keeps a conversion-complete flag for the host to poll.

The converter cannot stall. The ready signal therefore does not hold the producer back. It tells the producer whether the result will be kept. An offer made while ready is low is dropped, and the registers keep their old contents.

Ready goes low only while a byte pair is part-way through being read. When the host has read the first byte of a pair, no new result may replace the pair until the host reads the other byte. A write to the control register abandons a started pair at once. In continuous operation, results that the host never reads are simply overwritten.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, both data bytes read 0x00, the complete flag is 0 and res_ready is 1.
- R2: Format code 2'b00 (left): a stored result d puts d[9:2] in the high byte and {d[1:0], 6'b0} in the low byte.
- R3: Format code 2'b01 (right): the high byte is {6'b0, d[9:8]} and the low byte is d[7:0].
- R4: Format code 2'b10 (left signed): the layout is the same as left, except that bit 7 of the high byte holds the inverse of d[9].
- R5: Format code 2'b11 (8-bit): the high byte is 0x00 and the low byte is d[9:2]. In this format, reads never lower res_ready.
- R6: When the stored result used left or left-signed format, a high-byte read drops res_ready from the next cycle. Results offered while ready is low are discarded. A later low-byte read raises res_ready again from the cycle after it.
- R7: When the stored result used right format, the roles swap. A low-byte read drops res_ready, and a high-byte read raises it again.
- R8: While res_ready is 1, every offered result is stored one cycle later, whether or not the previous result was read.
- R9: Storing a result sets the complete flag on the next cycle. Further stores leave it set.
- R10: A ctl_wr pulse, or a read of either data byte, clears the complete flag on the next cycle. If a result is stored in the same cycle, the flag stays set.
- R11: A ctl_wr pulse raises res_ready from the next cycle, even when a pair read has been started.
- R12: The format field is sampled only when a result is stored. Changing it alters neither the bytes already held nor the interlock roles of the pair already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | A conversion result is offered this cycle |
| res_ready | output | 1 | An offered result will be stored; low while a pair read is under way |
| res_data | input | 10 | Conversion result |
| fmt | input | 2 | Format code: 00 left, 01 right, 10 left signed, 11 8-bit |
| rd_hi | input | 1 | Host read strobe for the high data byte |
| rd_lo | input | 1 | Host read strobe for the low data byte |
| ctl_wr | input | 1 | Host write strobe for the control register |
| data_hi | output | 8 | High data byte |
| data_lo | output | 8 | Low data byte |
| done | output | 1 | Conversion-complete flag |

## Verification
A wrong stored format or a wrong justification path is visible on data_hi and data_lo one cycle after the store. An interlock that arms or releases on the wrong strobe shows up on res_ready one cycle after the read. It then also shows up as data bytes that change, or fail to change, on the next offer. A flag with the wrong set or clear priority is visible on done in the cycle after the strobe. So every internal fault reaches the ports within two cycles of the stimulus that exposes it.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT   = 2'b00,
    FMT_RIGHT  = 2'b01,
    FMT_SIGNED = 2'b10,
    FMT_BYTE   = 2'b11
  } fmt_e;

  // Which byte read starts a pair for a given format; 2'b00 = none.
  // Bit 1 = high byte first, bit 0 = low byte first.
  function automatic logic [1:0] first_byte(input fmt_e f);
    case (f)
      FMT_LEFT, FMT_SIGNED: first_byte = 2'b10;
      FMT_RIGHT:            first_byte = 2'b01;
      default:              first_byte = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/adc_res_formatter.sv
module adc_res_formatter
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  fmt_e              fmt,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] left_pair;
  logic [PAIR_W-1:0] right_pair;
  logic [PAIR_W-1:0] sign_mask;
  logic [PAIR_W-1:0] pair;

  assign left_pair  = {res, {PAD_W{1'b0}}};
  assign right_pair = {{PAD_W{1'b0}}, res};
  assign sign_mask  = {1'b1, {(PAIR_W-1){1'b0}}};

  always_comb begin
    case (fmt)
      FMT_LEFT:   pair = left_pair;
      FMT_SIGNED: pair = left_pair ^ sign_mask;
      FMT_RIGHT:  pair = right_pair;
      default:    pair = {{BYTE_W{1'b0}}, res[RES_W-1 -: BYTE_W]};
    endcase
  end

  assign hi = pair[PAIR_W-1 -: BYTE_W];
  assign lo = pair[BYTE_W-1:0];
endmodule

// File: rtl/adc_res_interlock.sv
module adc_res_interlock
  import adc_res_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  fmt_e held_fmt,
  input  logic rd_hi,
  input  logic rd_lo,
  input  logic ctl_wr,
  output logic locked
);
  logic [1:0] first;
  logic       arm;
  logic       release_lk;

  assign first      = first_byte(held_fmt);
  assign arm        = (first[1] & rd_hi) | (first[0] & rd_lo);
  assign release_lk = ctl_wr | (first[1] & rd_lo) | (first[0] & rd_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          locked <= 1'b0;
    else if (release_lk) locked <= 1'b0;
    else if (arm)        locked <= 1'b1;
  end
endmodule

// File: rtl/adc_res_flag.sv
module adc_res_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [RES_W-1:0]  res_data,
  input  logic [1:0]        fmt,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              ctl_wr,
  output logic [BYTE_W-1:0] data_hi,
  output logic [BYTE_W-1:0] data_lo,
  output logic              done
);
  logic [BYTE_W-1:0] fmt_hi, fmt_lo;
  fmt_e              fmt_in;
  fmt_e              held_fmt;
  logic              locked;
  logic              store;

  assign fmt_in    = fmt_e'(fmt);
  assign res_ready = ~locked;
  assign store     = res_valid & res_ready;

  adc_res_formatter #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .res (res_data),
    .fmt (fmt_in),
    .hi  (fmt_hi),
    .lo  (fmt_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_hi  <= '0;
      data_lo  <= '0;
      held_fmt <= FMT_LEFT;
    end else if (store) begin
      data_hi  <= fmt_hi;
      data_lo  <= fmt_lo;
      held_fmt <= fmt_in;
    end
  end

  adc_res_interlock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .held_fmt (held_fmt),
    .rd_hi    (rd_hi),
    .rd_lo    (rd_lo),
    .ctl_wr   (ctl_wr),
    .locked   (locked)
  );

  adc_res_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (store),
    .clr_i (ctl_wr | rd_hi | rd_lo),
    .flag  (done)
  );
endmodule

// File: rtl/adc_res_chk.sv
module adc_res_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              res_ready,
  input logic              rd_hi,
  input logic              rd_lo,
  input logic              ctl_wr,
  input logic [BYTE_W-1:0] data_hi,
  input logic [BYTE_W-1:0] data_lo,
  input logic              done
);
  AST_BLOCKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> ($stable(data_hi) && $stable(data_lo))); // R6
  AST_STORE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> done); // R9
  AST_CTL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !(res_valid && res_ready)) |=> !done); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_hi || rd_lo) && !(res_valid && res_ready)) |=> !done); // R10
  AST_CTL_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> res_ready); // R11
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> ($stable(data_hi) && $stable(data_lo))); // R8
endmodule

bind adc_result_regs adc_res_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .rd_hi     (rd_hi),
  .rd_lo     (rd_lo),
  .ctl_wr    (ctl_wr),
  .data_hi   (data_hi),
  .data_lo   (data_lo),
  .done      (done)
);

// File: tb/adc_result_regs_test.sv
module adc_result_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic       res_ready;
  logic [9:0] res_data = '0;
  logic [1:0] fmt = 2'b00;
  logic       rd_hi = 1'b0, rd_lo = 1'b0, ctl_wr = 1'b0;
  logic [7:0] data_hi, data_lo;
  logic       done;

  int tests = 0;
  int fails = 0;

  // Reference state, kept from the requirements only
  logic [7:0] m_hi = 8'h00, m_lo = 8'h00;
  logic       m_done = 1'b0, m_lock = 1'b0;
  logic [1:0] m_fmt = 2'b00;

  always #5 clk = ~clk;

  adc_result_regs uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .fmt(fmt), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .ctl_wr(ctl_wr), .data_hi(data_hi), .data_lo(data_lo), .done(done)
  );

  function automatic logic [15:0] exp_pair(input logic [1:0] f, input logic [9:0] d);
    case (f)
      2'b00:   exp_pair = {d[9:2], d[1:0], 6'b0};
      2'b01:   exp_pair = {6'b0, d[9:8], d[7:0]};
      2'b10:   exp_pair = {~d[9], d[8:2], d[1:0], 6'b0};
      default: exp_pair = {8'h00, d[9:2]};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, {24'h0, data_hi}, {24'h0, m_hi});
    check(req, {24'h0, data_lo}, {24'h0, m_lo});
    check(req, {31'h0, done}, {31'h0, m_done});
    check(req, {31'h0, res_ready}, {31'h0, ~m_lock});
  endtask

  // One cycle: drive at negedge, update the model at the edge, compare after it.
  task automatic step(input logic v, input logic [9:0] d, input logic [1:0] f,
                      input logic rh, input logic rl, input logic cw, input string req);
    logic st, arm, rel, fh, fl;
    @(negedge clk);
    res_valid = v; res_data = d; fmt = f; rd_hi = rh; rd_lo = rl; ctl_wr = cw;
    @(posedge clk);
    st  = v && !m_lock;
    fh  = (m_fmt == 2'b00) || (m_fmt == 2'b10);
    fl  = (m_fmt == 2'b01);
    arm = (fh && rh) || (fl && rl);
    rel = cw || (fh && rl) || (fl && rh);
    if (rel) m_lock = 1'b0; else if (arm) m_lock = 1'b1;
    if (st) m_done = 1'b1; else if (cw || rh || rl) m_done = 1'b0;
    if (st) begin {m_hi, m_lo} = exp_pair(f, d); m_fmt = f; end
    #2;
    check_all(req);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #2;
    check_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;

    // Formats with a fixed result
    step(1, 10'h2C5, 2'b00, 0, 0, 0, "R2 left");
    step(1, 10'h2C5, 2'b01, 0, 0, 0, "R3 right");
    step(1, 10'h2C5, 2'b10, 0, 0, 0, "R4 left signed");
    step(1, 10'h0C5, 2'b10, 0, 0, 0, "R4 signed low half");
    step(1, 10'h2C5, 2'b11, 0, 0, 0, "R5 8-bit");
    step(0, 0, 2'b00, 1, 0, 0, "R5 high read no lock");
    step(1, 10'h3FF, 2'b11, 0, 0, 0, "R5 stored after read");
    step(0, 0, 2'b00, 0, 1, 0, "R5 low read no lock");
    step(1, 10'h001, 2'b00, 0, 0, 0, "R8 stored after read");

    // Left interlock
    step(0, 0, 2'b00, 1, 0, 0, "R6 high read arms");
    step(1, 10'h155, 2'b00, 0, 0, 0, "R6 result dropped");
    step(1, 10'h0AA, 2'b01, 0, 0, 0, "R6 still dropped");
    step(0, 0, 2'b00, 0, 1, 0, "R6 low read releases");
    step(1, 10'h155, 2'b01, 0, 0, 0, "R6 store after release");

    // Right interlock, reversed roles
    step(0, 0, 2'b00, 1, 0, 0, "R7 high read no arm");
    step(1, 10'h2AA, 2'b01, 0, 0, 0, "R7 store");
    step(0, 0, 2'b00, 0, 1, 0, "R7 low read arms");
    step(1, 10'h111, 2'b00, 0, 0, 0, "R7 dropped");
    step(0, 0, 2'b00, 1, 0, 0, "R7 high read releases");

    // Overwrite and flag persistence
    step(1, 10'h123, 2'b00, 0, 0, 0, "R8 first");
    step(1, 10'h321, 2'b00, 0, 0, 0, "R9 flag stays");
    step(1, 10'h0F0, 2'b01, 0, 0, 0, "R12 new format on store");
    step(0, 0, 2'b00, 0, 0, 0, "R12 mode change holds bytes");
    step(0, 0, 2'b00, 0, 1, 0, "R12 held right roles arm");
    step(0, 0, 2'b00, 0, 0, 1, "R11 ctl_wr releases");
    step(1, 10'h200, 2'b00, 0, 0, 1, "R10 store beats clear");
    step(0, 0, 2'b00, 0, 0, 1, "R10 ctl_wr clears");
    step(1, 10'h201, 2'b00, 0, 0, 0, "R9 set");
    step(0, 0, 2'b00, 0, 1, 0, "R10 read clears");
    step(0, 0, 2'b00, 1, 0, 0, "R6 arm again");
    step(0, 0, 2'b00, 1, 0, 1, "R11 ctl_wr over arm");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 3) != 0, 10'($urandom), 2'($urandom),
           ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 13) == 0,
           "R2-R12 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule